// File: doc/BRIEF.md
# Committed Slow-Domain Configuration Shadow

This block keeps three configuration registers (reset enable, wakeup enable and control) in the fast bus clock domain. It also keeps a separate shadow copy of each one in a slow, always-on domain. Logic in the slow domain reads only the shadows. A write to a fast register therefore changes nothing in the slow domain until software commits it. Software commits by writing 1 to a sync bit. The sync bit is set while the transfer is in flight and clears itself once the slow side has captured the values. Software polls it to learn that the commit is done.

The crossing uses a toggle request and a toggle acknowledge, each passed through a two-flop synchronizer. When a commit starts, the fast register values are frozen into a transfer snapshot. The snapshot stays stable until the acknowledge returns. The slow domain is modelled as a clock-enable pulse on the common clock.

A gate for incoming hardware reset requests uses the shadowed reset enable. A request from a maskable source whose shadow bit is 0 is dropped. The gate also flags a drop that a missing commit may have caused.

Top module: `cfg_shadow_commit`

## Requirements
- R1: After synchronous reset, the fast registers and the shadows hold their reset values (reset enable 0x00, wakeup enable 0x00, control 0x01), `sync_busy` is 0 and `shadow_stale` is 0.
- R2: A write with `wr_sel` 0 (reset enable), 1 (wakeup enable) or 2 (control) updates only the fast copy on the next clock edge. The shadow outputs stay unchanged.
- R3: A write with `wr_sel` 3 and `wr_data[0]`=1 sets `sync_busy` on the next edge. With `wr_data[0]`=0 it has no effect.
- R4: A commit loads all three shadows together with the fast values held when it started. `sync_busy` clears by itself only after the load.
- R5: A sync write while `sync_busy` is 1 merges into the pending commit. It starts no second commit, and fast writes made meanwhile are not loaded by it.
- R6: A reset request from a maskable source (`MASKABLE` bit set; bit 0 clear by default) is dropped when its shadowed reset-enable bit is 0, even if the fast bit is 1. With the shadow bit at 1, it fires.
- R7: A reset request from a non-maskable source always fires, one cycle after the request.
- R8: A dropped request raises `rst_hint` when the shadowed reset enable differs from the fast reset enable. Otherwise `rst_hint` stays 0.
- R9: `shadow_stale` is 1 one cycle after any shadow differs from its fast register, and 0 one cycle after all three match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock |
| rst | input | 1 | Synchronous active-high reset |
| slow_ce | input | 1 | Slow-domain clock enable |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 reset-en, 1 wakeup-en, 2 control, 3 sync |
| wr_data | input | REG_W | Write data |
| cfg_rst_en | output | REG_W | Fast reset-enable register |
| cfg_wake_en | output | REG_W | Fast wakeup-enable register |
| cfg_ctrl | output | REG_W | Fast control register |
| sync_busy | output | 1 | Commit in flight (pollable sync bit) |
| sh_rst_en | output | REG_W | Shadowed reset enable |
| sh_wake_en | output | REG_W | Shadowed wakeup enable |
| sh_ctrl | output | REG_W | Shadowed control |
| shadow_stale | output | 1 | Some shadow differs from its fast register |
| rst_req_valid | input | 1 | Hardware reset request |
| rst_req_src | input | SRC_W | Requesting source index |
| rst_fire | output | 1 | Request accepted |
| rst_blocked | output | 1 | Request dropped by the shadowed enable |
| rst_hint | output | 1 | Dropped while the shadow is out of date |

## Verification
The bench writes fast registers and confirms that the shadows do not move and that the stale flag rises. A design that leaks writes straight into the slow domain would show the new values at once. It writes 0 to the sync bit to catch a design that treats the bit as plain read-write and either clears or sets it. During a pending commit it writes new values and issues a second sync write. A design that queues a second commit, or reads live registers instead of a snapshot, loads the late values or pulses busy again. Reset requests from a source whose fast bit is 1 and shadow bit is 0 catch a gate wired to the fast register. A request from the non-maskable source catches over-masking.

// File: rtl/cfg_shadow_pkg.sv
package cfg_shadow_pkg;
  typedef enum logic [1:0] {
    SEL_RST_EN  = 2'd0,
    SEL_WAKE_EN = 2'd1,
    SEL_CTRL    = 2'd2,
    SEL_SYNC    = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/cs_sync2.sv
module cs_sync2 (
  input  logic clk,
  input  logic rst,
  input  logic ce,
  input  logic d,
  output logic q
);
  logic meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= 1'b0;
      q    <= 1'b0;
    end else if (ce) begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/cs_fast_regs.sv
module cs_fast_regs
  import cfg_shadow_pkg::*;
#(
  parameter int          REG_W     = 8,
  parameter logic [REG_W-1:0] RST_EN_INIT = '0,
  parameter logic [REG_W-1:0] WAKE_INIT   = '0,
  parameter logic [REG_W-1:0] CTRL_INIT   = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [REG_W-1:0] wr_data,
  input  logic             ack_sync,
  output logic [REG_W-1:0] rst_en_q,
  output logic [REG_W-1:0] wake_en_q,
  output logic [REG_W-1:0] ctrl_q,
  output logic [REG_W-1:0] snap_rst_en,
  output logic [REG_W-1:0] snap_wake_en,
  output logic [REG_W-1:0] snap_ctrl,
  output logic             req_tgl,
  output logic             busy
);
  logic ack_prev;
  logic ack_edge;
  logic launch;
  reg_sel_e sel;

  assign sel      = reg_sel_e'(wr_sel);
  assign ack_edge = ack_sync ^ ack_prev;
  assign launch   = wr_en && (sel == SEL_SYNC) && wr_data[0] && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      rst_en_q  <= RST_EN_INIT;
      wake_en_q <= WAKE_INIT;
      ctrl_q    <= CTRL_INIT;
    end else if (wr_en) begin
      case (sel)
        SEL_RST_EN:  rst_en_q  <= wr_data;
        SEL_WAKE_EN: wake_en_q <= wr_data;
        SEL_CTRL:    ctrl_q    <= wr_data;
        default:     ;
      endcase
    end
  end

  // Commit launch and completion; a sync write during busy is merged
  always_ff @(posedge clk) begin
    if (rst) begin
      busy         <= 1'b0;
      req_tgl      <= 1'b0;
      ack_prev     <= 1'b0;
      snap_rst_en  <= RST_EN_INIT;
      snap_wake_en <= WAKE_INIT;
      snap_ctrl    <= CTRL_INIT;
    end else begin
      ack_prev <= ack_sync;
      if (launch) begin
        busy         <= 1'b1;
        req_tgl      <= ~req_tgl;
        snap_rst_en  <= rst_en_q;
        snap_wake_en <= wake_en_q;
        snap_ctrl    <= ctrl_q;
      end else if (ack_edge) begin
        busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/cs_slow_shadow.sv
module cs_slow_shadow #(
  parameter int          REG_W     = 8,
  parameter logic [REG_W-1:0] RST_EN_INIT = '0,
  parameter logic [REG_W-1:0] WAKE_INIT   = '0,
  parameter logic [REG_W-1:0] CTRL_INIT   = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             slow_ce,
  input  logic             req_sync,
  input  logic [REG_W-1:0] snap_rst_en,
  input  logic [REG_W-1:0] snap_wake_en,
  input  logic [REG_W-1:0] snap_ctrl,
  output logic [REG_W-1:0] sh_rst_en,
  output logic [REG_W-1:0] sh_wake_en,
  output logic [REG_W-1:0] sh_ctrl,
  output logic             ack_tgl
);
  logic req_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_prev   <= 1'b0;
      ack_tgl    <= 1'b0;
      sh_rst_en  <= RST_EN_INIT;
      sh_wake_en <= WAKE_INIT;
      sh_ctrl    <= CTRL_INIT;
    end else if (slow_ce) begin
      req_prev <= req_sync;
      if (req_sync != req_prev) begin
        sh_rst_en  <= snap_rst_en;
        sh_wake_en <= snap_wake_en;
        sh_ctrl    <= snap_ctrl;
        ack_tgl    <= ~ack_tgl;
      end
    end
  end
endmodule

// File: rtl/cs_rst_gate.sv
module cs_rst_gate #(
  parameter int          REG_W    = 8,
  parameter int          SRC_W    = 3,
  parameter logic [REG_W-1:0] MASKABLE = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [SRC_W-1:0] req_src,
  input  logic [REG_W-1:0] fast_rst_en,
  input  logic [REG_W-1:0] fast_wake_en,
  input  logic [REG_W-1:0] fast_ctrl,
  input  logic [REG_W-1:0] sh_rst_en,
  input  logic [REG_W-1:0] sh_wake_en,
  input  logic [REG_W-1:0] sh_ctrl,
  output logic             fire,
  output logic             blocked,
  output logic             hint,
  output logic             stale
);
  logic masked;
  logic rst_differs;

  assign masked      = MASKABLE[req_src] && !sh_rst_en[req_src];
  assign rst_differs = sh_rst_en != fast_rst_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      fire    <= 1'b0;
      blocked <= 1'b0;
      hint    <= 1'b0;
      stale   <= 1'b0;
    end else begin
      fire    <= req_valid && !masked;
      blocked <= req_valid && masked;
      hint    <= req_valid && masked && rst_differs;
      stale   <= rst_differs || (sh_wake_en != fast_wake_en) || (sh_ctrl != fast_ctrl);
    end
  end
endmodule

// File: rtl/cfg_shadow_commit.sv
module cfg_shadow_commit #(
  parameter int          REG_W       = 8,
  parameter int          SRC_W       = $clog2(REG_W),
  parameter logic [REG_W-1:0] RST_EN_INIT = 8'h00,
  parameter logic [REG_W-1:0] WAKE_INIT   = 8'h00,
  parameter logic [REG_W-1:0] CTRL_INIT   = 8'h01,
  parameter logic [REG_W-1:0] MASKABLE    = 8'hFE
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             slow_ce,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] cfg_rst_en,
  output logic [REG_W-1:0] cfg_wake_en,
  output logic [REG_W-1:0] cfg_ctrl,
  output logic             sync_busy,
  output logic [REG_W-1:0] sh_rst_en,
  output logic [REG_W-1:0] sh_wake_en,
  output logic [REG_W-1:0] sh_ctrl,
  output logic             shadow_stale,
  input  logic             rst_req_valid,
  input  logic [SRC_W-1:0] rst_req_src,
  output logic             rst_fire,
  output logic             rst_blocked,
  output logic             rst_hint
);
  logic [REG_W-1:0] snap_rst_en, snap_wake_en, snap_ctrl;
  logic req_tgl, req_sync, ack_tgl, ack_sync;

  cs_fast_regs #(
    .REG_W(REG_W), .RST_EN_INIT(RST_EN_INIT), .WAKE_INIT(WAKE_INIT), .CTRL_INIT(CTRL_INIT)
  ) u_fast (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .ack_sync(ack_sync), .rst_en_q(cfg_rst_en), .wake_en_q(cfg_wake_en), .ctrl_q(cfg_ctrl),
    .snap_rst_en(snap_rst_en), .snap_wake_en(snap_wake_en), .snap_ctrl(snap_ctrl),
    .req_tgl(req_tgl), .busy(sync_busy)
  );

  cs_sync2 u_req_sync (.clk(clk), .rst(rst), .ce(slow_ce), .d(req_tgl), .q(req_sync));

  cs_slow_shadow #(
    .REG_W(REG_W), .RST_EN_INIT(RST_EN_INIT), .WAKE_INIT(WAKE_INIT), .CTRL_INIT(CTRL_INIT)
  ) u_slow (
    .clk(clk), .rst(rst), .slow_ce(slow_ce), .req_sync(req_sync),
    .snap_rst_en(snap_rst_en), .snap_wake_en(snap_wake_en), .snap_ctrl(snap_ctrl),
    .sh_rst_en(sh_rst_en), .sh_wake_en(sh_wake_en), .sh_ctrl(sh_ctrl), .ack_tgl(ack_tgl)
  );

  cs_sync2 u_ack_sync (.clk(clk), .rst(rst), .ce(1'b1), .d(ack_tgl), .q(ack_sync));

  cs_rst_gate #(.REG_W(REG_W), .SRC_W(SRC_W), .MASKABLE(MASKABLE)) u_gate (
    .clk(clk), .rst(rst), .req_valid(rst_req_valid), .req_src(rst_req_src),
    .fast_rst_en(cfg_rst_en), .fast_wake_en(cfg_wake_en), .fast_ctrl(cfg_ctrl),
    .sh_rst_en(sh_rst_en), .sh_wake_en(sh_wake_en), .sh_ctrl(sh_ctrl),
    .fire(rst_fire), .blocked(rst_blocked), .hint(rst_hint), .stale(shadow_stale)
  );
endmodule

// File: rtl/cfg_shadow_commit_chk.sv
module cfg_shadow_commit_chk #(
  parameter int          REG_W    = 8,
  parameter int          SRC_W    = 3,
  parameter logic [REG_W-1:0] MASKABLE = 8'hFE
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic [1:0]       wr_sel,
  input logic [REG_W-1:0] wr_data,
  input logic             sync_busy,
  input logic [REG_W-1:0] sh_rst_en,
  input logic [REG_W-1:0] sh_wake_en,
  input logic [REG_W-1:0] sh_ctrl,
  input logic             rst_req_valid,
  input logic [SRC_W-1:0] rst_req_src,
  input logic             rst_fire,
  input logic             rst_blocked,
  input logic             rst_hint
);
  AST_SYNC_SETS: assert property (@(posedge clk) disable iff (rst)
    (!sync_busy && wr_en && wr_sel == 2'd3 && wr_data[0]) |=> sync_busy); // R3
  AST_SYNC_ZERO_NOP: assert property (@(posedge clk) disable iff (rst)
    (!sync_busy && wr_en && wr_sel == 2'd3 && !wr_data[0]) |=> !sync_busy); // R3
  AST_SHADOW_ONLY_IN_COMMIT: assert property (@(posedge clk) disable iff (rst)
    !($stable(sh_rst_en) && $stable(sh_wake_en) && $stable(sh_ctrl)) |-> $past(sync_busy)); // R4
  AST_MASKED_DROP: assert property (@(posedge clk) disable iff (rst)
    (rst_req_valid && MASKABLE[rst_req_src] && !sh_rst_en[rst_req_src]) |=> (rst_blocked && !rst_fire)); // R6
  AST_UNMASKABLE_FIRES: assert property (@(posedge clk) disable iff (rst)
    (rst_req_valid && !MASKABLE[rst_req_src]) |=> rst_fire); // R7
  AST_HINT_NEEDS_DROP: assert property (@(posedge clk) disable iff (rst)
    rst_hint |-> rst_blocked); // R8
  AST_GATE_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rst_fire, rst_blocked})); // R6
endmodule

bind cfg_shadow_commit cfg_shadow_commit_chk #(
  .REG_W(REG_W), .SRC_W(SRC_W), .MASKABLE(MASKABLE)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .sync_busy(sync_busy), .sh_rst_en(sh_rst_en), .sh_wake_en(sh_wake_en), .sh_ctrl(sh_ctrl),
  .rst_req_valid(rst_req_valid), .rst_req_src(rst_req_src),
  .rst_fire(rst_fire), .rst_blocked(rst_blocked), .rst_hint(rst_hint)
);

// File: tb/test_cfg_shadow_commit.sv
module test_cfg_shadow_commit;
  localparam int REG_W = 8;
  localparam int SRC_W = 3;
  localparam int SLOW_DIV = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic slow_ce = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_sel = '0;
  logic [REG_W-1:0] wr_data = '0;
  logic rst_req_valid = 1'b0;
  logic [SRC_W-1:0] rst_req_src = '0;
  logic [REG_W-1:0] cfg_rst_en, cfg_wake_en, cfg_ctrl, sh_rst_en, sh_wake_en, sh_ctrl;
  logic sync_busy, shadow_stale, rst_fire, rst_blocked, rst_hint;

  int checks = 0;
  int errors = 0;
  int commits_seen = 0;
  logic [3*REG_W-1:0] sb_q[$];
  logic [REG_W-1:0] m_rst, m_wake, m_ctrl;

  always #4 clk = ~clk;

  int div_cnt = 0;
  always @(posedge clk) begin
    div_cnt <= (div_cnt == SLOW_DIV-1) ? 0 : div_cnt + 1;
    slow_ce <= (div_cnt == SLOW_DIV-1);
  end

  cfg_shadow_commit i_cfg_shadow_commit (
    .clk(clk), .rst(rst), .slow_ce(slow_ce), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .cfg_rst_en(cfg_rst_en), .cfg_wake_en(cfg_wake_en), .cfg_ctrl(cfg_ctrl),
    .sync_busy(sync_busy), .sh_rst_en(sh_rst_en), .sh_wake_en(sh_wake_en), .sh_ctrl(sh_ctrl),
    .shadow_stale(shadow_stale), .rst_req_valid(rst_req_valid), .rst_req_src(rst_req_src),
    .rst_fire(rst_fire), .rst_blocked(rst_blocked), .rst_hint(rst_hint)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [REG_W-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    case (sel)
      2'd0: m_rst = d;
      2'd1: m_wake = d;
      2'd2: m_ctrl = d;
      default: ;
    endcase
  endtask

  // Driver: launches a commit and pushes the expected shadow triple
  task automatic commit();
    sb_q.push_back({m_rst, m_wake, m_ctrl});
    wr(2'd3, 8'h01);
    chk("R3 busy after sync write", sync_busy, 1'b1);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 400 && sync_busy; i++) @(negedge clk);
    chk("R4 busy self-clears", sync_busy, 1'b0);
  endtask

  task automatic req(input logic [SRC_W-1:0] src, input logic f, input logic b, input logic h, input string tag);
    @(negedge clk);
    rst_req_valid = 1'b1; rst_req_src = src;
    @(negedge clk);
    rst_req_valid = 1'b0;
    chk({tag, " fire"}, rst_fire, f);
    chk({tag, " blocked"}, rst_blocked, b);
    chk({tag, " hint"}, rst_hint, h);
  endtask

  // Monitor: on each busy fall, pop and compare shadows
  logic busy_prev = 1'b0;
  always @(negedge clk) begin
    if (!rst) begin
      if (busy_prev && !sync_busy) begin
        commits_seen++;
        if (sb_q.size() == 0) begin
          checks++; errors++;
          $display("FAIL R5 unexpected commit completion actual=1 expected=0");
        end else begin
          logic [3*REG_W-1:0] e;
          e = sb_q.pop_front();
          chk("R4 shadows after commit", {sh_rst_en, sh_wake_en, sh_ctrl}, {8'h00, e});
        end
      end
      busy_prev <= sync_busy;
    end
  end

  initial begin
    fork
      begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    join_none
    m_rst = 8'h00; m_wake = 8'h00; m_ctrl = 8'h01;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    chk("R1 fast regs", {cfg_rst_en, cfg_wake_en, cfg_ctrl}, 24'h000001);
    chk("R1 shadows", {sh_rst_en, sh_wake_en, sh_ctrl}, 24'h000001);
    chk("R1 busy", sync_busy, 1'b0);
    chk("R1 stale", shadow_stale, 1'b0);

    // R2 fast-only writes
    wr(2'd0, 8'h06); wr(2'd1, 8'hA5); wr(2'd2, 8'h3C);
    @(negedge clk);
    chk("R2 fast regs", {cfg_rst_en, cfg_wake_en, cfg_ctrl}, 24'h06A53C);
    chk("R2 shadows unchanged", {sh_rst_en, sh_wake_en, sh_ctrl}, 24'h000001);
    chk("R9 stale set", shadow_stale, 1'b1);

    // R6/R8: fast bit 1 but shadow 0
    req(3'd1, 1'b0, 1'b1, 1'b1, "R6 R8 stale drop");

    // R3 writing 0 to sync is ignored
    wr(2'd3, 8'h00);
    repeat (30) @(negedge clk);
    chk("R3 zero write no busy", sync_busy, 1'b0);
    chk("R3 zero write shadows", {sh_rst_en, sh_wake_en, sh_ctrl}, 24'h000001);

    commit();
    wait_idle();
    @(negedge clk);
    chk("R9 stale cleared", shadow_stale, 1'b0);

    req(3'd1, 1'b1, 1'b0, 1'b0, "R6 enabled fires");
    req(3'd3, 1'b0, 1'b1, 1'b0, "R8 no hint when in sync");
    req(3'd0, 1'b1, 1'b0, 1'b0, "R7 unmaskable");

    // R5 merge
    wr(2'd0, 8'h18);
    commit();
    wr(2'd0, 8'h60);
    chk("R5 still busy", sync_busy, 1'b1);
    wr(2'd3, 8'h01);
    wait_idle();
    repeat (60) @(negedge clk);
    chk("R5 no second commit", commits_seen, 2);
    chk("R5 late write not loaded", sh_rst_en, 8'h18);
    chk("R9 stale after merge", shadow_stale, 1'b1);
    req(3'd5, 1'b0, 1'b1, 1'b1, "R8 hint on stale drop");

    commit();
    wait_idle();
    @(negedge clk);
    chk("R4 final shadow", sh_rst_en, 8'h60);
    chk("R4 scoreboard drained", sb_q.size(), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule